// File: doc/BRIEF.md
# Aperture Address Remapper

This block rewrites the 32-bit addresses issued by a set of bus masters so that each one sees its own view of the system. Every master's 4 GB space is cut into sixteen 256 MB windows, selected by the top four address bits. For each window a per-master map entry names a destination slave and the window at that slave where the access lands. The top nibble of the address is replaced by that destination window, and the low 28 bits pass through unchanged. A destination slave of zero means the window leads nowhere, and such an access is flagged as a decode error.

Software programs the maps through a simple word-wide register port. Each master owns a group of four 32-bit map words. Writes to those words land in a shadow copy only. The live map a master uses changes only when software writes the update register with that master's bit set. This lets a full map be rewritten without exposing half-written states, and it lets several masters switch to new maps on the same clock edge.

Each master has its own translation lane with a valid strobe. The lane returns the destination slave, the rewritten address and the error flag one clock after the request.

Top module: `aprmap_top`

## Requirements
- R1: After reset, out_valid is low, every shadow and live map word is zero, and any translation reports slave 0 with out_noslv set.
- R2: The window index is address bits [31:28]. The translated address carries the window's destination offset in bits [31:28] and the request's bits [27:0] unchanged.
- R3: Destination slave entries sit at group word offset 0x0 for windows 0-7 and at 0x4 for windows 8-15. Within the first word, window i occupies bits [4i+3:4i]; within the second word, window i+8 occupies the same bits.
- R4: Destination offset entries use the same packing as R3, at group word offsets 0x8 (windows 0-7) and 0xC (windows 8-15).
- R5: A destination slave value of 0 sets out_noslv and drives out_slave to 0. Any nonzero value clears out_noslv.
- R6: Writing a map word has no effect on translation until that master is committed.
- R7: Master n's group starts at byte address n*16. Writing the update register at 0x100 copies the shadow map of every master whose bit n is set in the written data into its live map, all in one cycle, and leaves the other masters untouched.
- R8: out_valid[n] is tr_valid[n] delayed by exactly one clock. The outputs of lane n are produced from the request presented in that earlier cycle.
- R9: reg_rdata is registered. One cycle after an address is presented, it shows the last value written to that map word. It shows 0 for the update register and for unmapped addresses.
- R10: A translation presented in the same cycle as a commit uses the live map from before the commit. The following request uses the new map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| tr_valid | input | NUM_MST | Per-master translation request valid |
| tr_addr | input | NUM_MST*32 | Per-master request address, master n at bits [32n+31:32n] |
| out_valid | output | NUM_MST | Per-master translated result valid |
| out_slave | output | NUM_MST*4 | Destination slave per master |
| out_addr | output | NUM_MST*32 | Translated address per master |
| out_noslv | output | NUM_MST | Decode error: the window maps to slave 0 |

## Verification
A commit of the live map can land in the same cycle as a translation request on the master being committed. The bench provokes this by asserting the update write and a lane request on the same clock edge. It checks that the returned slave and address come from the map in force before the commit. It then checks that the very next request sees the committed map. Separately, shadow writes made before the commit are checked for having no effect on the lane outputs.

// File: rtl/aprmap_pkg.sv
package aprmap_pkg;
  localparam int ENTRY_W   = 4;
  localparam int NUM_APER  = 16;
  localparam int WORD_W    = 32;
  localparam int MAP_WORDS = 4;
  localparam int MAP_W     = MAP_WORDS * WORD_W;
  localparam int PER_WORD  = WORD_W / ENTRY_W;

  typedef enum logic [1:0] {
    W_SEL_LO = 2'd0,
    W_SEL_HI = 2'd1,
    W_OFS_LO = 2'd2,
    W_OFS_HI = 2'd3
  } map_word_e;

  typedef struct packed {
    logic [ENTRY_W-1:0] slave;
    logic [ENTRY_W-1:0] window;
  } aper_entry_t;
endpackage

// File: rtl/aprmap_shadow.sv
module aprmap_shadow
  import aprmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic             commit,
  output logic [MAP_W-1:0] shd_q,
  output logic [MAP_W-1:0] act_q
);
  logic [WORD_W-1:0] shd [MAP_WORDS];
  logic [WORD_W-1:0] act [MAP_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < MAP_WORDS; w++) shd[w] <= '0;
    end else if (wr_en) begin
      shd[wr_word] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < MAP_WORDS; w++) act[w] <= '0;
    end else if (commit) begin
      for (int w = 0; w < MAP_WORDS; w++) act[w] <= shd[w];
    end
  end

  genvar g;
  generate
    for (g = 0; g < MAP_WORDS; g++) begin : g_flat
      assign shd_q[g*WORD_W +: WORD_W] = shd[g];
      assign act_q[g*WORD_W +: WORD_W] = act[g];
    end
  endgenerate
endmodule

// File: rtl/aprmap_lane.sv
module aprmap_lane
  import aprmap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAP_W-1:0]  act_map,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              o_valid,
  output logic [ENTRY_W-1:0] o_slave,
  output logic [ADDR_W-1:0] o_addr,
  output logic              o_noslv
);
  localparam int LOW_W   = ADDR_W - ENTRY_W;
  localparam int TABLE_W = NUM_APER * ENTRY_W;

  logic [TABLE_W-1:0] sel_tbl, ofs_tbl;
  logic [ENTRY_W-1:0] idx;
  aper_entry_t        ent;

  assign sel_tbl = act_map[0 +: TABLE_W];
  assign ofs_tbl = act_map[TABLE_W +: TABLE_W];
  assign idx     = in_addr[ADDR_W-1 -: ENTRY_W];

  always_comb begin
    ent.slave  = sel_tbl[idx*ENTRY_W +: ENTRY_W];
    ent.window = ofs_tbl[idx*ENTRY_W +: ENTRY_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_slave <= '0;
      o_addr  <= '0;
      o_noslv <= 1'b1;
    end else begin
      o_valid <= in_valid;
      if (in_valid) begin
        o_slave <= ent.slave;
        o_addr  <= {ent.window, in_addr[LOW_W-1:0]};
        o_noslv <= (ent.slave == '0);
      end
    end
  end
endmodule

// File: rtl/aprmap_top.sv
module aprmap_top
  import aprmap_pkg::*;
#(
  parameter int NUM_MST = 10,
  parameter int ADDR_W  = 32,
  parameter int GRP_W   = 4,
  parameter int REG_AW  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [WORD_W-1:0]          reg_wdata,
  output logic [WORD_W-1:0]          reg_rdata,
  input  logic [NUM_MST-1:0]         tr_valid,
  input  logic [NUM_MST*ADDR_W-1:0]  tr_addr,
  output logic [NUM_MST-1:0]         out_valid,
  output logic [NUM_MST*ENTRY_W-1:0] out_slave,
  output logic [NUM_MST*ADDR_W-1:0]  out_addr,
  output logic [NUM_MST-1:0]         out_noslv
);
  localparam int GRP_LSB = 4;
  localparam int UPD_BIT = GRP_LSB + GRP_W;
  localparam logic [REG_AW-1:0] UPD_OFS = REG_AW'(1) << UPD_BIT;

  logic [GRP_W-1:0]       grp;
  logic [1:0]             word;
  logic                   in_map, is_upd;
  logic [NUM_MST-1:0]     commit;
  logic [NUM_MST*MAP_W-1:0] shd_all, act_all;

  assign grp    = reg_addr[GRP_LSB +: GRP_W];
  assign word   = reg_addr[3:2];
  assign in_map = (reg_addr[REG_AW-1:UPD_BIT] == '0) && (reg_addr[1:0] == 2'b00)
                  && (int'(grp) < NUM_MST);
  assign is_upd = (reg_addr == UPD_OFS);
  assign commit = (reg_we && is_upd) ? reg_wdata[NUM_MST-1:0] : '0;

  genvar m;
  generate
    for (m = 0; m < NUM_MST; m++) begin : g_mst
      logic wr_hit;
      assign wr_hit = reg_we && in_map && (int'(grp) == m);

      aprmap_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_hit),
        .wr_word (word),
        .wr_data (reg_wdata),
        .commit  (commit[m]),
        .shd_q   (shd_all[m*MAP_W +: MAP_W]),
        .act_q   (act_all[m*MAP_W +: MAP_W])
      );

      aprmap_lane #(.ADDR_W(ADDR_W)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .act_map  (act_all[m*MAP_W +: MAP_W]),
        .in_valid (tr_valid[m]),
        .in_addr  (tr_addr[m*ADDR_W +: ADDR_W]),
        .o_valid  (out_valid[m]),
        .o_slave  (out_slave[m*ENTRY_W +: ENTRY_W]),
        .o_addr   (out_addr[m*ADDR_W +: ADDR_W]),
        .o_noslv  (out_noslv[m])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (in_map) begin
      reg_rdata <= shd_all[int'(grp)*MAP_W + int'(word)*WORD_W +: WORD_W];
    end else begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/aprmap_chk.sv
module aprmap_chk
  import aprmap_pkg::*;
#(
  parameter int NUM_MST = 10,
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 9
) (
  input logic                       clk,
  input logic                       rst,
  input logic [REG_AW-1:0]          reg_addr,
  input logic [WORD_W-1:0]          reg_rdata,
  input logic [NUM_MST-1:0]         tr_valid,
  input logic [NUM_MST*ADDR_W-1:0]  tr_addr,
  input logic [NUM_MST-1:0]         out_valid,
  input logic [NUM_MST*ENTRY_W-1:0] out_slave,
  input logic [NUM_MST*ADDR_W-1:0]  out_addr,
  input logic [NUM_MST-1:0]         out_noslv
);
  localparam logic [REG_AW-1:0] UPD_OFS = REG_AW'(1) << (REG_AW - 1);
  localparam int LOW_W = ADDR_W - ENTRY_W;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0)); // R1

  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(tr_valid))); // R8

  AST_UPD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_addr) == UPD_OFS) |-> (reg_rdata == '0)); // R9

  genvar n;
  generate
    for (n = 0; n < NUM_MST; n++) begin : g_lane
      AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid[n]) |->
          (out_addr[n*ADDR_W +: LOW_W] == $past(tr_addr[n*ADDR_W +: LOW_W]))); // R2

      AST_NOSLV_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid[n] |-> (out_noslv[n] == (out_slave[n*ENTRY_W +: ENTRY_W] == '0))); // R5
    end
  endgenerate
endmodule

bind aprmap_top aprmap_chk #(
  .NUM_MST (NUM_MST),
  .ADDR_W  (ADDR_W),
  .REG_AW  (REG_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .tr_valid  (tr_valid),
  .tr_addr   (tr_addr),
  .out_valid (out_valid),
  .out_slave (out_slave),
  .out_addr  (out_addr),
  .out_noslv (out_noslv)
);

// File: tb/tb_aprmap_top.sv
module tb_aprmap_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM  = 10;
  localparam int AW  = 32;
  localparam int RAW = 9;
  localparam logic [RAW-1:0] UPD = 9'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NM-1:0] tr_valid = '0;
  logic [NM*AW-1:0] tr_addr = '0;
  logic [NM-1:0] out_valid;
  logic [NM*4-1:0] out_slave;
  logic [NM*AW-1:0] out_addr;
  logic [NM-1:0] out_noslv;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] shd_m [NM][4];
  logic [31:0] act_m [NM][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  aprmap_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_valid(tr_valid),
    .tr_addr(tr_addr), .out_valid(out_valid), .out_slave(out_slave),
    .out_addr(out_addr), .out_noslv(out_noslv)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(logic [31:0] w, int i);
    return w[i*4 +: 4];
  endfunction

  function automatic logic [3:0] exp_slave(int m, logic [31:0] a);
    int idx = int'(a[31:28]);
    return nib(act_m[m][idx / 8], idx % 8);
  endfunction

  function automatic logic [31:0] exp_addr(int m, logic [31:0] a);
    int idx = int'(a[31:28]);
    return {nib(act_m[m][2 + idx / 8], idx % 8), a[27:0]};
  endfunction

  function automatic logic [RAW-1:0] waddr(int m, int w);
    return RAW'(m * 16 + w * 4);
  endfunction

  task automatic model_commit(logic [31:0] mask);
    for (int m = 0; m < NM; m++)
      if (mask[m]) for (int w = 0; w < 4; w++) act_m[m][w] = shd_m[m][w];
  endtask

  task automatic reg_write(logic [RAW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == UPD) model_commit(d);
    else if (a[8] == 1'b0 && int'(a[7:4]) < NM && a[1:0] == 2'b00)
      shd_m[a[7:4]][a[3:2]] = d;
  endtask

  task automatic reg_read(logic [RAW-1:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic xlate(int m, logic [31:0] a, bit commit_now, logic [31:0] mask, string req);
    logic [3:0] es;
    logic [31:0] ea;
    @(negedge clk);
    tr_valid = '0; tr_valid[m] = 1'b1;
    tr_addr[m*AW +: AW] = a;
    if (commit_now) begin reg_we = 1'b1; reg_addr = UPD; reg_wdata = mask; end
    es = exp_slave(m, a);
    ea = exp_addr(m, a);
    @(negedge clk);
    tr_valid = '0; reg_we = 1'b0;
    if (commit_now) model_commit(mask);
    chk({req, " valid"}, 32'(out_valid), 32'(1) << m);
    chk({req, " slave"}, 32'(out_slave[m*4 +: 4]), 32'(es));
    chk({req, " addr"}, out_addr[m*AW +: AW], ea);
    chk({req, " noslv R5"}, 32'(out_noslv[m]), 32'(es == 4'd0));
  endtask

  task automatic program_master(int m, logic [31:0] s0, logic [31:0] s1,
                                logic [31:0] o0, logic [31:0] o1);
    reg_write(waddr(m, 0), s0);
    reg_write(waddr(m, 1), s1);
    reg_write(waddr(m, 2), o0);
    reg_write(waddr(m, 3), o1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd2024);
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 4; w++) begin shd_m[m][w] = '0; act_m[m][w] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    reg_read(waddr(4, 2), 32'd0, "R1 shadow");
    xlate(0, 32'h8123_4567, 0, 0, "R1 xlate");

    // R3 R4 R9: program master 0 with a known map and read it back
    program_master(0, 32'h7650_4321, 32'h0000_00A9, 32'h0123_4567, 32'hFEDC_BA98);
    reg_read(waddr(0, 0), 32'h7650_4321, "R9 R3 readback w0");
    reg_read(waddr(0, 3), 32'hFEDC_BA98, "R9 R4 readback w3");
    // R6: not yet committed
    xlate(0, 32'h2000_0010, 0, 0, "R6 before commit");
    reg_write(UPD, 32'h1);
    reg_read(UPD, 32'd0, "R9 update reads zero");
    reg_read(9'h0A0, 32'd0, "R9 unmapped group");
    // R2 R3 R4 R5: sweep all windows
    for (int i = 0; i < 16; i++)
      xlate(0, {4'(i), 28'h0ABC_DEF ^ 28'(i * 977)}, 0, 0, "R2 R3 R4 sweep");

    // R7: commit master 3 only
    program_master(3, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444);
    program_master(0, 32'h5555_5555, 32'h5555_5555, 32'h6666_6666, 32'h6666_6666);
    reg_write(UPD, 32'h8);
    xlate(3, 32'h9000_0001, 0, 0, "R7 master3 committed");
    xlate(0, 32'h9000_0001, 0, 0, "R7 master0 held");

    // R10: commit in same cycle as request, then next request
    xlate(0, 32'h0000_1234, 1, 32'h1, "R10 same cycle old map");
    xlate(0, 32'h0000_1234, 0, 0, "R10 next cycle new map");

    // R7: random maps for all masters, committed together with 0x3ff
    for (int m = 0; m < NM; m++)
      program_master(m, $urandom, $urandom, $urandom, $urandom);
    reg_write(UPD, 32'h3FF);
    for (int k = 0; k < 60; k++)
      xlate(int'($urandom % NM), $urandom, 0, 0, "R7 R2 random");

    // R8: all lanes at once, then idle
    @(negedge clk);
    tr_valid = '1;
    for (int m = 0; m < NM; m++) tr_addr[m*AW +: AW] = $urandom;
    @(negedge clk);
    chk("R8 all valid", 32'(out_valid), 32'h3FF);
    for (int m = 0; m < NM; m++) begin
      chk("R8 lane addr", out_addr[m*AW +: AW], exp_addr(m, tr_addr[m*AW +: AW]));
      chk("R8 lane slave", 32'(out_slave[m*4 +: 4]), 32'(exp_slave(m, tr_addr[m*AW +: AW])));
    end
    tr_valid = '0;
    @(negedge clk);
    chk("R8 idle", 32'(out_valid), 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule